// File: doc/BRIEF.md
# IO coherency aperture decoder

This block sits at the entry of an IO coherency port and decides, for every incoming IO request, which path the request takes. A request is routed through the coherent cache path only when its address falls inside one programmable aperture. Any other request goes directly to memory. The aperture is set up through four write-only registers on a small register bus: an enable bit, a partial-write enable bit, a size code and a base.

The size code gives an aperture of 2^(code+2) KB, so code 0 is 4 KB, 0x11 is 512 MB and 0x12 is 1 GB. The base holds the aperture start address shifted right by 12. An aperture is legal only under all of these conditions:
- its start is aligned to its size;
- it fits inside the address space;
- the second-level cache is present and enabled;
- the L1 data cache is enabled.

While the port is enabled, an illegal setup sets a sticky error flag and stops every hit. Writing 0 to the enable register clears the flag.

Top module: `coh_aperture_dec`

## Requirements
- R1: After reset the enable, partial-enable, size code and base registers are all zero, and req_valid_o, req_coh_o and cfg_err_o are low.
- R2: With the port enabled and the setup legal, a request whose address lies in [base<<12, (base<<12) + 2^(code+12)) gives req_valid_o=1 and req_coh_o=1 one cycle after the request. An aperture that spans the whole address space hits every address.
- R3: A request outside the aperture, including the first address past its end and the last address below its start, gives req_valid_o=1 and req_coh_o=0 one cycle later.
- R4: While the enable register is 0, no request is flagged coherent.
- R5: A request with req_partial_i=1 is flagged coherent only when the partial-enable register is 1. Full requests do not depend on that register.
- R6: While enabled, a base that is not aligned to the aperture size sets cfg_err_o one cycle later. Hits are blocked from the cycle in which the setup becomes illegal.
- R7: While enabled, a size code greater than ADDR_W-12 (an aperture larger than the address space) sets cfg_err_o and blocks hits.
- R8: While enabled, l2_present_i=0, l2_enabled_i=0 or l1d_enabled_i=0 sets cfg_err_o and blocks hits.
- R9: cfg_err_o stays set, and hits stay blocked, after the setup is made legal again. A write of 0 to the enable register clears it in the next cycle.
- R10: Register write offsets on reg_addr_i are: 0 enable (bit 0), 1 partial enable (bit 0), 2 size code (low SIZE_W bits), 3 base (address bits ADDR_W-1..12). A write applies to requests presented in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | ADDR_W-12 | Register write data |
| l2_present_i | input | 1 | Second-level cache is present |
| l2_enabled_i | input | 1 | Second-level cache is enabled |
| l1d_enabled_i | input | 1 | L1 data cache is enabled |
| req_valid_i | input | 1 | IO request valid |
| req_addr_i | input | ADDR_W | IO request address |
| req_partial_i | input | 1 | Request is a partial write |
| req_valid_o | output | 1 | Registered request valid |
| req_coh_o | output | 1 | Request goes through the coherent path |
| cfg_err_o | output | 1 | Sticky illegal-aperture flag |

## Verification
The bench builds the block with ADDR_W=24 and SIZE_W=5. With these values the largest legal size code is 12, which gives an aperture covering the whole 16 MB space, and code 13 is the first oversize code. Both ends of the size range can therefore be tested with a few writes. The tests also cover:
- the smallest 4 KB aperture at its exact edges;
- a 64 KB aperture with a misaligned base;
- each environment input being dropped while the port is enabled.

// File: rtl/coh_ap_pkg.sv
package coh_ap_pkg;
  localparam int PAGE_SH = 12;

  typedef enum logic [1:0] {
    OFS_EN   = 2'd0,
    OFS_PART = 2'd1,
    OFS_SIZE = 2'd2,
    OFS_BASE = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/coh_ap_regs.sv
module coh_ap_regs
  import coh_ap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5,
  localparam int BASE_W = ADDR_W - PAGE_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [BASE_W-1:0] wdata_i,
  output logic              en_o,
  output logic              part_en_o,
  output logic [SIZE_W-1:0] size_code_o,
  output logic [BASE_W-1:0] base_o,
  output logic              clr_err_o
);
  reg_ofs_e ofs;
  assign ofs = reg_ofs_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o        <= 1'b0;
      part_en_o   <= 1'b0;
      size_code_o <= '0;
      base_o      <= '0;
    end else if (we_i) begin
      case (ofs)
        OFS_EN:   en_o        <= wdata_i[0];
        OFS_PART: part_en_o   <= wdata_i[0];
        OFS_SIZE: size_code_o <= wdata_i[SIZE_W-1:0];
        default:  base_o      <= wdata_i;
      endcase
    end
  end

  // writing 0 to the enable register releases the sticky error
  assign clr_err_o = we_i && (ofs == OFS_EN) && !wdata_i[0];
endmodule

// File: rtl/coh_ap_legal.sv
module coh_ap_legal
  import coh_ap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5,
  localparam int BASE_W = ADDR_W - PAGE_SH,
  localparam int MAX_CODE = ADDR_W - PAGE_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [SIZE_W-1:0] size_code_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              l2_present_i,
  input  logic              l2_enabled_i,
  input  logic              l1d_enabled_i,
  output logic [ADDR_W-1:0] low_mask_o,
  output logic              suppress_o,
  output logic              err_o
);
  logic misaligned, oversize, env_bad, illegal, err_q;

  // bits below the aperture size
  always_comb begin
    for (int i = 0; i < ADDR_W; i++)
      low_mask_o[i] = (int'(size_code_i) + PAGE_SH) > i;
  end

  assign misaligned = |(base_i & low_mask_o[ADDR_W-1:PAGE_SH]);
  assign oversize   = int'(size_code_i) > MAX_CODE;
  assign env_bad    = !(l2_present_i && l2_enabled_i && l1d_enabled_i);
  assign illegal    = misaligned || oversize || env_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (clr_i)   err_q <= 1'b0;
    else if (en_i && illegal) err_q <= 1'b1;
  end

  assign err_o      = err_q;
  assign suppress_o = illegal || err_q;

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !clr_i |=> err_q);
  assert_err_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !err_q);
  assert_misalign_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && misaligned && !clr_i |=> err_q);
  assert_oversize_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && oversize && !clr_i |=> err_q);
  assert_env_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !l1d_enabled_i && !clr_i |=> err_q);
endmodule

// File: rtl/coh_ap_match.sv
module coh_ap_match
  import coh_ap_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int BASE_W = ADDR_W - PAGE_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_partial_i,
  input  logic [ADDR_W-1:0] low_mask_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              en_i,
  input  logic              part_en_i,
  input  logic              suppress_i,
  output logic              vld_o,
  output logic              coh_o
);
  logic [ADDR_W-1:0] base_addr;
  logic in_ap, coh_d, vld_q, coh_q;

  assign base_addr = {base_i, {PAGE_SH{1'b0}}};
  assign in_ap     = ((req_addr_i ^ base_addr) & ~low_mask_i) == '0;
  assign coh_d     = req_valid_i && en_i && !suppress_i && in_ap &&
                     (!req_partial_i || part_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      coh_q <= 1'b0;
    end else begin
      vld_q <= req_valid_i;
      coh_q <= coh_d;
    end
  end

  assign vld_o = vld_q;
  assign coh_o = coh_q;

  assert_coh_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coh_q |-> vld_q);
  assert_off_no_coh_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !coh_q);
  assert_partial_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_partial_i && !part_en_i |=> !coh_q);
  assert_suppress_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suppress_i |=> !coh_q);
endmodule

// File: rtl/coh_aperture_dec.sv
module coh_aperture_dec
  import coh_ap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5,
  localparam int BASE_W = ADDR_W - PAGE_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [BASE_W-1:0] reg_wdata_i,
  input  logic              l2_present_i,
  input  logic              l2_enabled_i,
  input  logic              l1d_enabled_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_partial_i,
  output logic              req_valid_o,
  output logic              req_coh_o,
  output logic              cfg_err_o
);
  logic              en, part_en, clr_err, suppress;
  logic [SIZE_W-1:0] size_code;
  logic [BASE_W-1:0] base;
  logic [ADDR_W-1:0] low_mask;

  coh_ap_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .en_o(en), .part_en_o(part_en), .size_code_o(size_code),
    .base_o(base), .clr_err_o(clr_err)
  );

  coh_ap_legal #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_legal (
    .clk_i, .rst_ni,
    .en_i(en), .clr_i(clr_err), .size_code_i(size_code), .base_i(base),
    .l2_present_i, .l2_enabled_i, .l1d_enabled_i,
    .low_mask_o(low_mask), .suppress_o(suppress), .err_o(cfg_err_o)
  );

  coh_ap_match #(.ADDR_W(ADDR_W)) i_match (
    .clk_i, .rst_ni,
    .req_valid_i, .req_addr_i, .req_partial_i,
    .low_mask_i(low_mask), .base_i(base), .en_i(en), .part_en_i(part_en),
    .suppress_i(suppress), .vld_o(req_valid_o), .coh_o(req_coh_o)
  );

  assert_err_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o && !clr_err |=> !req_coh_o);
endmodule

// File: tb/test_coh_aperture_dec.sv
module test_coh_aperture_dec;
  localparam int AW = 24;
  localparam int SW = 5;
  localparam int BW = AW - 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [BW-1:0] reg_wdata = '0;
  logic l2p = 1'b1, l2e = 1'b1, l1d = 1'b1;
  logic req_valid = 1'b0, req_partial = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_valid_o, req_coh_o, cfg_err_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  bit exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  coh_aperture_dec #(.ADDR_W(AW), .SIZE_W(SW)) i_coh_aperture_dec (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .l2_present_i(l2p), .l2_enabled_i(l2e), .l1d_enabled_i(l1d),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_partial_i(req_partial),
    .req_valid_o, .req_coh_o, .cfg_err_o
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per registered request
  always @(negedge clk) begin
    if (rst_n && req_valid_o) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL unexpected output: actual %0b expected none", req_coh_o);
      end else begin
        automatic bit e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, req_coh_o, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
      reg_we = 1'b0;
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input logic p, input bit e, input string tag);
    @(negedge clk);
    reg_we = 1'b0;
    req_valid = 1'b1; req_addr = a; req_partial = p;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] ofs, input logic [BW-1:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    reg_we = 1'b1; reg_addr = ofs; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic cfg(input logic [SW-1:0] code, input logic [BW-1:0] base);
    wr(2'd0, '0);
    wr(2'd2, BW'(code));
    wr(2'd3, base);
    wr(2'd0, BW'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid_o", req_valid_o, 1'b0);
    chk("R1 reset coh_o", req_coh_o, 1'b0);
    chk("R1 reset err_o", cfg_err_o, 1'b0);
    rst_n = 1'b1;
    // registers zero: base 0, code 0, enable 0 -> no hit even at address 0
    send(24'h000000, 1'b0, 1'b0, "R1 R4 reset enable off");
    idle(2);

    // smallest aperture, exact edges
    cfg(5'd0, 12'h005);
    send(24'h005000, 1'b0, 1'b1, "R2 R10 4K first");
    send(24'h005FFF, 1'b0, 1'b1, "R2 4K last");
    send(24'h006000, 1'b0, 1'b0, "R3 4K past end");
    send(24'h004FFF, 1'b0, 1'b0, "R3 4K below start");
    idle(2);
    chk("R2 legal no err", cfg_err_o, 1'b0);

    // 64 KB aperture
    cfg(5'd4, 12'h010);
    send(24'h01ABCD, 1'b0, 1'b1, "R2 64K inside");
    send(24'h020000, 1'b0, 1'b0, "R3 64K past end");
    send(24'h00FFFF, 1'b0, 1'b0, "R3 64K below");
    // partial writes
    send(24'h011000, 1'b1, 1'b0, "R5 partial gated");
    send(24'h011000, 1'b0, 1'b1, "R5 full not gated");
    wr(2'd1, BW'(1));
    send(24'h011000, 1'b1, 1'b1, "R5 R10 partial allowed");
    send(24'h031000, 1'b1, 1'b0, "R5 partial outside");
    idle(2);

    // whole address space
    cfg(5'd12, 12'h000);
    send(24'hFFFFFF, 1'b0, 1'b1, "R2 full space top");
    send(24'h000000, 1'b0, 1'b1, "R2 full space bottom");
    wr(2'd0, '0);
    send(24'h123456, 1'b0, 1'b0, "R4 R10 disabled");
    idle(2);
    chk("R2 full space no err", cfg_err_o, 1'b0);

    // misaligned base
    cfg(5'd4, 12'h010);
    wr(2'd3, 12'h011);
    send(24'h011000, 1'b0, 1'b0, "R6 misaligned blocks");
    idle(1);
    chk("R6 misaligned err", cfg_err_o, 1'b1);
    wr(2'd3, 12'h010);
    send(24'h010000, 1'b0, 1'b0, "R9 sticky blocks");
    idle(1);
    chk("R9 sticky err", cfg_err_o, 1'b1);
    wr(2'd0, '0);
    chk("R9 cleared", cfg_err_o, 1'b0);
    wr(2'd0, BW'(1));
    send(24'h010000, 1'b0, 1'b1, "R9 hits after clear");
    idle(2);
    chk("R9 stays clear", cfg_err_o, 1'b0);

    // oversize code
    cfg(5'd13, 12'h000);
    send(24'h000100, 1'b0, 1'b0, "R7 oversize blocks");
    idle(1);
    chk("R7 oversize err", cfg_err_o, 1'b1);

    // environment checks
    cfg(5'd4, 12'h010);
    idle(1);
    chk("R8 legal before", cfg_err_o, 1'b0);
    @(negedge clk); l1d = 1'b0;
    send(24'h010000, 1'b0, 1'b0, "R8 l1d off blocks");
    idle(1);
    chk("R8 l1d off err", cfg_err_o, 1'b1);
    l1d = 1'b1;
    cfg(5'd4, 12'h010);
    @(negedge clk); l2p = 1'b0;
    idle(1);
    chk("R8 l2 absent err", cfg_err_o, 1'b1);
    l2p = 1'b1;
    cfg(5'd4, 12'h010);
    @(negedge clk); l2e = 1'b0;
    idle(1);
    chk("R8 l2 off err", cfg_err_o, 1'b1);
    l2e = 1'b1;
    cfg(5'd4, 12'h010);
    send(24'h01FFFF, 1'b0, 1'b1, "R8 restored hit");
    idle(3);

    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 missing outputs: actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule